// File: doc/BRIEF.md
# Ethernet Transmit Framer with Automatic Padding

The block turns a byte stream taken from a transmit FIFO into a serial Ethernet frame, one bit per clock. It stays idle until the channel is free and the FIFO holds enough bytes. It then sends a 56-bit alternating preamble and the start delimiter, followed by the payload bytes with the least significant bit first. If the frame is short, it can add zero bytes. It can also append a 32-bit frame check sequence computed over everything sent after the delimiter.

Two per-frame options are captured when a frame starts. The pad option extends a short body (all bytes after the delimiter, before the check sequence) to 60 bytes, so that with the check sequence the frame carries 64 bytes. The check-sequence option adds the 32 CRC bits. The block takes a FIFO byte only at the boundary of a serialized byte. If no byte is ready when one is needed in the middle of a frame, the frame is aborted and an error is flagged. A one-cycle done pulse marks a frame that completed normally.

Top module: `eth_tx_framer`

## Requirements
- R1: The block leaves idle only on a clock edge at which chan_ok is 1, fifo_level is nonzero and fifo_level is at least start_thresh. The first frame bit appears in the next cycle, and tx_valid stays high without a gap until the frame ends.
- R2: The first 56 bits sent alternate 1,0,1,0,… starting with 1.
- R3: The next 8 bits are 1,0,1,0,1,0,1,1 in that transmit order.
- R4: Each FIFO byte is then sent in FIFO order, bit 0 first, one bit per clock.
- R5: When pad is enabled for the frame and the frame has fewer than 60 FIFO bytes, zero bytes are sent after the data until the body is 60 bytes long.
- R6: When pad is disabled, or the frame has 60 or more bytes, no pad byte is sent.
- R7: When the check sequence is enabled, 32 bits follow the body. They are the complement of a CRC-32 with polynomial 04C11DB7h, preset to all ones, computed over the body bits in transmit order. The bit for the x^31 term is sent first.
- R8: When the check sequence is disabled, the frame ends directly after the last body bit.
- R9: tx_done is a one-cycle pulse in the cycle right after the last frame bit, with tx_valid low.
- R10: fifo_pop is high for exactly one cycle per byte taken. It is high only while fifo_valid is 1, and it occurs once for each FIFO byte of the frame.
- R11: If fifo_valid is 0 when a byte is needed (after the delimiter, or after a byte not marked last), the bit stream stops after the current byte. tx_err then pulses for one cycle and no tx_done is given for that frame.
- R12: pad_en and fcs_en are sampled when the frame starts. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_valid | input | 1 | FIFO head byte present |
| fifo_last | input | 1 | FIFO head byte ends the frame |
| fifo_level | input | LVL_W | Bytes currently in the FIFO |
| start_thresh | input | LVL_W | Fill level needed to start a frame |
| pad_en | input | 1 | Pad short frames with zeros |
| fcs_en | input | 1 | Append the check sequence |
| chan_ok | input | 1 | Channel access permitted |
| fifo_pop | output | 1 | FIFO head byte consumed this edge |
| tx_bit | output | 1 | Serial frame bit |
| tx_valid | output | 1 | tx_bit carries a frame bit |
| tx_done | output | 1 | Frame completed pulse |
| tx_err | output | 1 | Frame aborted on underrun pulse |

## Verification
The assertions assume that the FIFO head is stable between pops and that fifo_level counts the bytes that are actually present. They also assume that a frame's last byte is flagged before the FIFO runs dry, unless the test injects an underrun on purpose. The bench's FIFO model follows these rules: it derives data, valid, last and level from one read pointer that advances only on fifo_pop. Underruns are created only by limiting how many bytes are made available.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SFD, ST_DATA, ST_PAD, ST_FCS, ST_DONE, ST_ABORT
  } tx_state_t;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;

  // one CRC step on the bit-reversed register, fed with the transmitted bit
  function automatic logic [31:0] crc_bit_step(input logic [31:0] c, input logic b);
    crc_bit_step = (c >> 1) ^ ((c[0] ^ b) ? CRC_POLY_REFL : 32'h0);
  endfunction
endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic        bit_in,
  output logic [31:0] crc_q,
  output logic [31:0] crc_nxt
);
  import eth_tx_pkg::*;

  assign crc_nxt = crc_bit_step(crc_q, bit_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '1;
    else if (clr) crc_q <= '1;
    else if (en)  crc_q <= crc_nxt;
  end
endmodule

// File: rtl/eth_tx_shift.sv
module eth_tx_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              run,
  output logic              bit_o,
  output logic              last_bit
);
  localparam int BC_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh;
  logic [BC_W-1:0]   bcnt;

  assign bit_o    = sh[0];
  assign last_bit = (bcnt == BC_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      bcnt <= '0;
    end else if (load) begin
      sh   <= load_byte;
      bcnt <= '0;
    end else if (run) begin
      sh   <= sh >> 1;
      bcnt <= bcnt + 1'b1;
    end
  end
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int LVL_W     = 8,
  parameter int PRE_BYTES = 7,
  parameter int MIN_FRAME = 64,
  parameter int CNT_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       fifo_data,
  input  logic             fifo_valid,
  input  logic             fifo_last,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] start_thresh,
  input  logic             pad_en,
  input  logic             fcs_en,
  input  logic             chan_ok,
  output logic             fifo_pop,
  output logic             tx_bit,
  output logic             tx_valid,
  output logic             tx_done,
  output logic             tx_err
);
  import eth_tx_pkg::*;

  localparam int FCS_BITS   = 32;
  localparam int PAD_TARGET = MIN_FRAME - FCS_BITS / 8;
  localparam int PCNT_W     = $clog2(PRE_BYTES);
  localparam int FCNT_W     = $clog2(FCS_BITS);

  tx_state_t         state;
  logic [PCNT_W-1:0] pcnt;
  logic [CNT_W-1:0]  bcount;
  logic              last_r, pad_r, fcs_r;
  logic [31:0]       fcs_sh;
  logic [FCNT_W-1:0] fcnt;

  // named internal events
  logic start_go, active, slot_end, pre_end, pre_last, need_byte, underrun;
  logic body_slot, short_body, pad_more, body_end, pad_bit;
  logic ser_load, ser_bit, ser_last;
  logic [7:0]  ser_byte;
  logic [31:0] crc_q, crc_nxt;

  assign start_go   = (state == ST_IDLE) && chan_ok && (fifo_level != '0) &&
                      (fifo_level >= start_thresh);
  assign active     = (state == ST_PRE) || (state == ST_SFD) ||
                      (state == ST_DATA) || (state == ST_PAD);
  assign slot_end   = active && ser_last;
  assign pre_end    = slot_end && (state == ST_PRE);
  assign pre_last   = (pcnt == PCNT_W'(PRE_BYTES - 1));
  assign need_byte  = slot_end && ((state == ST_SFD) || ((state == ST_DATA) && !last_r));
  assign fifo_pop   = need_byte && fifo_valid;
  assign underrun   = need_byte && !fifo_valid;
  assign body_slot  = slot_end && (((state == ST_DATA) && last_r) || (state == ST_PAD));
  assign short_body = pad_r && (bcount < CNT_W'(PAD_TARGET));
  assign pad_more   = body_slot && short_body;
  assign body_end   = body_slot && !short_body;
  assign pad_bit    = (state == ST_PAD);

  always_comb begin
    ser_load = 1'b0;
    ser_byte = 8'h00;
    if (start_go) begin
      ser_load = 1'b1;
      ser_byte = PRE_BYTE;
    end else if (pre_end) begin
      ser_load = 1'b1;
      ser_byte = pre_last ? SFD_BYTE : PRE_BYTE;
    end else if (fifo_pop) begin
      ser_load = 1'b1;
      ser_byte = fifo_data;
    end else if (pad_more) begin
      ser_load = 1'b1;
    end
  end

  eth_tx_shift #(.BYTE_W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .load_byte(ser_byte),
    .run(active), .bit_o(ser_bit), .last_bit(ser_last)
  );

  eth_tx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(start_go),
    .en((state == ST_DATA) || (state == ST_PAD)),
    .bit_in(ser_bit), .crc_q(crc_q), .crc_nxt(crc_nxt)
  );

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    sat_inc = (v == '1) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pcnt   <= '0;
      bcount <= '0;
      last_r <= 1'b0;
      pad_r  <= 1'b0;
      fcs_r  <= 1'b0;
      fcs_sh <= '0;
      fcnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_go) begin
          state  <= ST_PRE;
          pcnt   <= '0;
          bcount <= '0;
          last_r <= 1'b0;
          pad_r  <= pad_en;
          fcs_r  <= fcs_en;
        end
        ST_PRE: if (slot_end) begin
          if (pre_last) state <= ST_SFD;
          else          pcnt  <= pcnt + 1'b1;
        end
        ST_SFD, ST_DATA, ST_PAD: begin
          if (underrun) begin
            state <= ST_ABORT;
          end else if (fifo_pop) begin
            state  <= ST_DATA;
            last_r <= fifo_last;
            bcount <= sat_inc(bcount);
          end else if (pad_more) begin
            state  <= ST_PAD;
            bcount <= sat_inc(bcount);
          end else if (body_end) begin
            state  <= fcs_r ? ST_FCS : ST_DONE;
            fcs_sh <= ~crc_nxt;
            fcnt   <= '0;
          end
        end
        ST_FCS: begin
          fcs_sh <= fcs_sh >> 1;
          fcnt   <= fcnt + 1'b1;
          if (fcnt == FCNT_W'(FCS_BITS - 1)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid = active || (state == ST_FCS);
  assign tx_bit   = (state == ST_FCS) ? fcs_sh[0] : ser_bit;
  assign tx_done  = (state == ST_DONE);
  assign tx_err   = (state == ST_ABORT);

  a_r1_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(chan_ok && (fifo_level >= start_thresh) && (fifo_level != '0)));
  a_r2_pre_ends_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pre_end |-> !tx_bit);
  a_r3_sfd_ends_one: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && (state == ST_SFD)) |-> tx_bit);
  a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pad_bit |-> !tx_bit);
  a_r9_done_after_bits: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> ($past(tx_valid) && !tx_valid));
  a_r10_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> fifo_valid);
  a_r11_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> (!tx_valid && !tx_done && $past(tx_valid)));
  a_r12_opts_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && $past(tx_valid)) |-> ($stable(pad_r) && $stable(fcs_r)));
endmodule

// File: tb/sim_eth_tx_framer.sv
module sim_eth_tx_framer;
  localparam int LVL_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] fifo_data;
  logic fifo_valid, fifo_last;
  logic [LVL_W-1:0] fifo_level;
  logic [LVL_W-1:0] start_thresh;
  logic pad_en, fcs_en, chan_ok;
  logic fifo_pop, tx_bit, tx_valid, tx_done, tx_err;

  always #2 clk = ~clk;

  eth_tx_framer #(.LVL_W(LVL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_valid(fifo_valid),
    .fifo_last(fifo_last), .fifo_level(fifo_level), .start_thresh(start_thresh),
    .pad_en(pad_en), .fcs_en(fcs_en), .chan_ok(chan_ok), .fifo_pop(fifo_pop),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_done(tx_done), .tx_err(tx_err)
  );

  // FIFO model
  logic [7:0] mem [0:127];
  int pops = 0, f_base = 0, f_len = 0, f_avail = 0;
  int rd;
  assign rd         = pops - f_base;
  assign fifo_valid = (rd < f_avail);
  assign fifo_last  = (rd == f_len - 1);
  assign fifo_data  = mem[rd[6:0]];
  assign fifo_level = (f_avail > rd) ? LVL_W'(f_avail - rd) : '0;

  always @(posedge clk) if (fifo_pop) pops <= pops + 1;

  // output monitor
  bit cap [0:4095];
  int ncap = 0, done_cnt = 0, err_cnt = 0, bad_done = 0;
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid) begin
        cap[ncap % 4096] <= tx_bit;
        ncap <= ncap + 1;
      end
      if (tx_done) begin
        done_cnt <= done_cnt + 1;
        if (!prev_valid || tx_valid) bad_done <= bad_done + 1;
      end
      if (tx_err) err_cnt <= err_cnt + 1;
      prev_valid <= tx_valid;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    pat = 8'((i * 37 + seed) ^ (i >> 1));
  endfunction

  task automatic load_frame(input int len, input int avail, input int seed);
    for (int i = 0; i < len; i++) mem[i] = pat(i, seed);
    f_base  = pops;
    f_len   = len;
    f_avail = avail;
  endtask

  task automatic wait_end(input int d0, input int e0, input int flip);
    int t = 0;
    while (done_cnt == d0 && err_cnt == e0 && t < 20000) begin
      @(negedge clk);
      t++;
      if (t == flip) begin
        pad_en = ~pad_en;
        fcs_en = ~fcs_en;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input int len, input bit pad, input bit fcs,
                        input int b0, input int d0, input int e0, input int p0);
    int body, expb, nb, bad;
    logic [31:0] c;
    bit b, fb;
    body = (pad && len < 60) ? 60 : len;
    expb = 64 + 8 * body + (fcs ? 32 : 0);
    nb   = ncap - b0;
    chk(nb == expb, pad ? "R5 frame bit count" : "R6 frame bit count", nb, expb);
    if (!fcs) chk(nb == 64 + 8 * body, "R8 no check bits", nb, 64 + 8 * body);
    bad = 0;
    for (int k = 0; k < 56; k++) if (cap[(b0 + k) % 4096] != ((k % 2) == 0)) bad++;
    chk(bad == 0, "R2 preamble", bad, 0);
    bad = 0;
    for (int k = 0; k < 8; k++)
      if (cap[(b0 + 56 + k) % 4096] != ((k >= 6) || ((k % 2) == 0))) bad++;
    chk(bad == 0, "R3 delimiter", bad, 0);
    bad = 0;
    for (int k = 0; k < 8 * len; k++)
      if (cap[(b0 + 64 + k) % 4096] != mem[k / 8][k % 8]) bad++;
    chk(bad == 0, "R4 data bits", bad, 0);
    bad = 0;
    for (int k = 8 * len; k < 8 * body; k++) if (cap[(b0 + 64 + k) % 4096]) bad++;
    chk(bad == 0, "R5 pad zeros", bad, 0);
    if (fcs) begin
      c = 32'hFFFFFFFF;
      for (int k = 0; k < 8 * body; k++) begin
        b  = (k < 8 * len) ? mem[k / 8][k % 8] : 1'b0;
        fb = c[31] ^ b;
        c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
      bad = 0;
      for (int i = 0; i < 32; i++)
        if (cap[(b0 + 64 + 8 * body + i) % 4096] != ~c[31 - i]) bad++;
      chk(bad == 0, "R7 check sequence", bad, 0);
    end
    chk(done_cnt - d0 == 1, "R9 done pulse", done_cnt - d0, 1);
    chk(bad_done == 0, "R9 done timing", bad_done, 0);
    chk(pops - p0 == len, "R10 pop count", pops - p0, len);
    chk(err_cnt == e0, "R11 no error", err_cnt - e0, 0);
  endtask

  task automatic run_frame(input int len, input bit pad, input bit fcs,
                           input int seed, input int flip);
    int b0, d0, e0, p0;
    b0 = ncap; d0 = done_cnt; e0 = err_cnt; p0 = pops;
    pad_en = pad;
    fcs_en = fcs;
    load_frame(len, len, seed);
    wait_end(d0, e0, flip);
    verify(len, pad, fcs, b0, d0, e0, p0);
  endtask

  task automatic t_reset;
    chk(tx_valid == 0, "R1 reset valid", tx_valid, 0);
    chk(tx_done == 0 && tx_err == 0, "R9 reset pulses", {tx_done, tx_err}, 0);
    chk(fifo_pop == 0, "R10 reset pop", fifo_pop, 0);
  endtask

  task automatic t_threshold;
    int b0, d0, e0, p0;
    b0 = ncap; d0 = done_cnt; e0 = err_cnt; p0 = pops;
    start_thresh = 16; pad_en = 1; fcs_en = 1;
    load_frame(20, 5, 9);
    repeat (40) @(negedge clk);
    chk(ncap == b0, "R1 below threshold", ncap - b0, 0);
    f_avail = 20;
    wait_end(d0, e0, 0);
    verify(20, 1, 1, b0, d0, e0, p0);
    start_thresh = 1;
  endtask

  task automatic t_channel;
    int b0, d0, e0, p0;
    b0 = ncap; d0 = done_cnt; e0 = err_cnt; p0 = pops;
    chan_ok = 0; pad_en = 0; fcs_en = 1;
    load_frame(12, 12, 21);
    repeat (40) @(negedge clk);
    chk(ncap == b0, "R1 channel blocked", ncap - b0, 0);
    chan_ok = 1;
    wait_end(d0, e0, 0);
    verify(12, 0, 1, b0, d0, e0, p0);
  endtask

  task automatic t_underrun;
    int b0, d0, e0, p0;
    b0 = ncap; d0 = done_cnt; e0 = err_cnt; p0 = pops;
    pad_en = 1; fcs_en = 1;
    load_frame(40, 8, 5);
    wait_end(d0, e0, 0);
    chk(err_cnt - e0 == 1, "R11 error pulse", err_cnt - e0, 1);
    chk(done_cnt == d0, "R11 no done", done_cnt - d0, 0);
    chk(ncap - b0 == 128, "R11 bits before stop", ncap - b0, 128);
    chk(pops - p0 == 8, "R10 pops before underrun", pops - p0, 8);
    f_avail = 0; f_len = 0;
  endtask

  initial begin
    rst_n = 0; start_thresh = 1; pad_en = 0; fcs_en = 0; chan_ok = 1;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_frame(20, 1, 1, 3, 0);    // R5 short, padded
    run_frame(70, 1, 1, 7, 0);    // R6 long, no pad
    run_frame(10, 0, 1, 11, 0);   // R6 pad off
    run_frame(30, 1, 0, 13, 0);   // R8 no check sequence
    run_frame(60, 1, 1, 17, 0);   // R6 exactly at pad target
    run_frame(59, 1, 1, 19, 0);   // R5 one byte short
    run_frame(15, 1, 1, 23, 100); // R12 options flipped mid-frame
    t_threshold();
    t_channel();
    t_underrun();
    run_frame(25, 0, 0, 29, 0);   // recovery after abort
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule